// File: doc/BRIEF.md
# Multichannel Serial Audio Transmitter

This block sends audio sample words over a three-wire serial audio link: a bit clock, a word-select line and one data line. Each half of the word-select period is one system word. A system word carries one to four data words back to back, and any spare bit positions are filled with padding. The host pushes words into a small first-in first-out buffer through a plain write strobe. The words leave the block in exactly the order they were written, most significant bit first.

Static configuration inputs set the following. They are expected to change only while reset is held.

- The number of data words per system word.
- The data word length and the system word length.
- The value of the padding bits.
- Whether data sits at the start or the end of the system word.
- Whether the data is delayed by one bit relative to the word-select edge.
- The sense of the bit clock and of the word select.

The bit clock is divided from the master clock. If the buffer is empty when a word is due, zeros are sent in its place and a sticky flag records the underflow.

Top module: `mc_audio_tx`

## Requirements
- R1: Data words appear on `sd_o` in the order in which they were accepted at the write port, each sent most significant bit first. Bit `cfg_dlen-1` of `wr_data` goes first, and bits above it are ignored.
- R2: The `cfg_chnl` code gives the number of data words per system word: 00 gives one, 01 gives two, 10 gives three and 11 gives four. The words of one system word occupy consecutive bit positions. With code 01 and `cfg_swl` = 2 x `cfg_dlen`, no padding bit is sent.
- R3: A system word is `cfg_swl` bit-clock periods long. It holds `cfg_swl` minus (words x `cfg_dlen`) padding bits. Padding is driven high when `cfg_pad_hi` is 1 and low when it is 0.
- R4: With `cfg_right_align` = 0, the data occupies the first bit positions of the system word and the padding follows it. With `cfg_right_align` = 1, the padding comes first and the data occupies the last positions.
- R5: With `cfg_delay` = 1, the word-select level changes one bit period before the first bit of a system word. With `cfg_delay` = 0, it changes together with that first bit. It changes at no other time.
- R6: Before inversion, word select is 0 for the first system word of each frame and 1 for the second. A frame is two system words. `cfg_ws_inv` = 1 inverts `ws_o`.
- R7: The bit clock period is 2 x HALF_DIV master clock cycles. `sd_o` and `ws_o` change only on the falling edge of the uninverted bit clock. `cfg_sck_inv` = 1 inverts `sck_o`.
- R8: The buffer holds DEPTH words. `wr_full` is high while it holds DEPTH words, and a write made while `wr_full` is high is discarded.
- R9: When a data word is due and the buffer is empty, all bits of that word are sent as 0. `underflow` then goes high and stays high until reset.
- R10: Synchronous reset (`rst_n` low) has these effects:
  - the buffer is emptied;
  - `sd_o` is set to 0;
  - `ws_o` equals `cfg_ws_inv`;
  - `sck_o` equals `cfg_sck_inv`;
  - `underflow` and `wr_full` are set to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the word buffer |
| wr_data | input | MAX_DW | Data word, right-justified |
| wr_full | output | 1 | Buffer holds DEPTH words |
| cfg_chnl | input | 2 | Data words per system word: 00=1, 01=2, 10=3, 11=4 |
| cfg_dlen | input | DLEN_W | Data word length in bits (4..MAX_DW) |
| cfg_swl | input | SWL_W | System word length in bits |
| cfg_pad_hi | input | 1 | Padding bit value |
| cfg_right_align | input | 1 | 0 puts data first, 1 puts padding first |
| cfg_delay | input | 1 | One-bit data delay after word-select change |
| cfg_sck_inv | input | 1 | Invert bit clock output |
| cfg_ws_inv | input | 1 | Invert word-select output |
| sck_o | output | 1 | Serial bit clock |
| ws_o | output | 1 | Word select |
| sd_o | output | 1 | Serial data |
| underflow | output | 1 | Sticky empty-buffer flag |

## Verification
The embedded assertions check the following on every cycle:

- the data and word-select lines hold between bit-clock falling edges;
- word select moves only at a system-word boundary;
- a buffer read happens only on a bit tick;
- the buffer never reports full and empty together;
- a full buffer stays full when nothing is read;
- the underflow flag never clears.

The bit-level content of the stream can only be shown by the bench scenarios. This covers word order, slot packing for each channel count, padding count, value and side, and the one-bit delay. The scenarios also show the zero substitution after underflow and the loss of writes made into a full buffer. The bench compares each of these against a model computed from the configuration.

// File: rtl/sat_pkg.sv
// Shared definitions for the multichannel serial audio transmitter.
package sat_pkg;

    // Channel-count codes carried on cfg_chnl.
    typedef enum logic [1:0] {
        CH_ONE   = 2'b00,
        CH_TWO   = 2'b01,
        CH_THREE = 2'b10,
        CH_FOUR  = 2'b11
    } chan_code_e;

    // Number of data words per system word for a channel-count code.
    function automatic logic [2:0] words_per_slot(input logic [1:0] code);
        case (chan_code_e'(code))
            CH_ONE:   return 3'd1;
            CH_TWO:   return 3'd2;
            CH_THREE: return 3'd3;
            default:  return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/sat_fifo.sv
// Show-ahead word buffer.
// Behaviour: a write is taken when wr_en is high and the buffer is not full,
// and rd_data always presents the oldest word.
// Assumption: rd_en is raised only while the buffer is not empty.
module sat_fifo #(
    parameter int DW    = 16,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          full,
    output logic          empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = AW + 1;

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          push, pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign push    = wr_en && !full;
    assign pop     = rd_en && !empty;
    assign rd_data = mem[rd_ptr];

    // Storage write; the array is not reset.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wr_data;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            count <= count + CW'(push) - CW'(pop);
        end
    end

    AST_FULL_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty)); // R8
    AST_DROP_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        full && !rd_en |=> full); // R8

endmodule

// File: rtl/sat_bitclk.sv
// Bit clock generator.
// Behaviour: sck_int toggles every HALF_DIV master cycles, starting low
// after reset. tick is high for the master cycle in which sck_int falls.
// Assumption: HALF_DIV >= 1.
module sat_bitclk #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic sck_int,
    output logic tick
);
    localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CNT_W-1:0] div_cnt;
    logic             flip;

    assign flip = (div_cnt == CNT_W'(HALF_DIV - 1));
    assign tick = flip && sck_int;

    // Half-period counter and bit clock toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_cnt <= '0;
            sck_int <= 1'b0;
        end else if (flip) begin
            div_cnt <= '0;
            sck_int <= ~sck_int;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

    AST_TICK_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !sck_int); // R7
    AST_RISE_NOT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !sck_int |-> !tick); // R7

endmodule

// File: rtl/sat_slot_seq.sv
// System-word sequencer and serializer.
// Behaviour:
//   - On each bit tick it registers one stream bit and the word-select level.
//   - It pops a buffer word at the start of each data word.
//   - It handles padding side and value, the one-bit delay and empty-buffer
//     substitution.
// Assumptions:
//   - Configuration is static outside reset.
//   - cfg_dlen is between 1 and MAX_DW.
//   - cfg_swl is at least words x cfg_dlen.
module sat_slot_seq
    import sat_pkg::*;
#(
    parameter int MAX_DW = 16,
    parameter int DLEN_W = 5,
    parameter int SWL_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [1:0]        cfg_chnl,
    input  logic [DLEN_W-1:0] cfg_dlen,
    input  logic [SWL_W-1:0]  cfg_swl,
    input  logic              cfg_pad_hi,
    input  logic              cfg_right_align,
    input  logic              cfg_delay,
    input  logic [MAX_DW-1:0] fifo_data,
    input  logic              fifo_empty,
    output logic              fifo_pop,
    output logic              sd_q,
    output logic              ws_q,
    output logic              underflow
);
    localparam int IDX_W = (MAX_DW > 1) ? $clog2(MAX_DW) : 1;
    localparam int XW    = SWL_W + 1;

    logic [SWL_W-1:0]  q;
    logic              half;
    logic [DLEN_W-1:0] bpos;
    logic [MAX_DW-1:0] shreg;

    logic [XW-1:0]     nbits, pad, dstart, dend, qx;
    logic              in_data, word_start, q_last, ws_next, bit_out;
    logic [MAX_DW-1:0] cur_word;
    logic [IDX_W-1:0]  msb_idx;

    // Slot geometry: where the data region starts and ends in this system word.
    always_comb begin
        nbits  = XW'(words_per_slot(cfg_chnl)) * XW'(cfg_dlen);
        pad    = XW'(cfg_swl) - nbits;
        dstart = cfg_right_align ? pad : '0;
        dend   = dstart + nbits;
        qx     = XW'(q);
    end

    // Per-bit decode: data or padding, next word load, outgoing bit, WS level.
    always_comb begin
        in_data    = (qx >= dstart) && (qx < dend);
        word_start = in_data && (bpos == '0);
        q_last     = (q == cfg_swl - SWL_W'(1));
        msb_idx    = IDX_W'(cfg_dlen - DLEN_W'(1));
        if (word_start) cur_word = fifo_empty ? '0 : fifo_data;
        else            cur_word = shreg;
        bit_out    = in_data ? cur_word[msb_idx] : cfg_pad_hi;
        ws_next    = (cfg_delay && q_last) ? ~half : half;
    end

    assign fifo_pop = tick && word_start && !fifo_empty;

    // Bit position, system-word parity and in-word position counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            half <= 1'b0;
            bpos <= '0;
        end else if (tick) begin
            q <= q_last ? '0 : q + 1'b1;
            if (q_last) half <= ~half;
            if (in_data) bpos <= (bpos == cfg_dlen - DLEN_W'(1)) ? '0 : bpos + 1'b1;
            else         bpos <= '0;
        end
    end

    // Output registers and the word shifter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sd_q  <= 1'b0;
            ws_q  <= 1'b0;
            shreg <= '0;
        end else if (tick) begin
            sd_q <= bit_out;
            ws_q <= ws_next;
            if (in_data) shreg <= cur_word << 1;
        end
    end

    // Sticky record of a word falling due with nothing buffered.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  underflow <= 1'b0;
        else if (tick && word_start && fifo_empty)   underflow <= 1'b1;
    end

    AST_SD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(sd_q)); // R7
    AST_WS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(ws_q)); // R7
    AST_WS_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        tick && (q != '0) && !q_last |=> $stable(ws_q)); // R5
    AST_POP_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> tick); // R1
    AST_UNDERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> underflow); // R9

endmodule

// File: rtl/mc_audio_tx.sv
// Multichannel serial audio transmitter top.
// Behaviour: the word buffer, bit clock divider and slot serializer are
// joined here, and the polarity settings are applied to the outputs.
// Assumption: configuration inputs change only while rst_n is low.
module mc_audio_tx #(
    parameter int MAX_DW   = 16,
    parameter int DEPTH    = 8,
    parameter int HALF_DIV = 2,
    parameter int SWL_W    = 7,
    parameter int DLEN_W   = $clog2(MAX_DW + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [MAX_DW-1:0] wr_data,
    output logic              wr_full,
    input  logic [1:0]        cfg_chnl,
    input  logic [DLEN_W-1:0] cfg_dlen,
    input  logic [SWL_W-1:0]  cfg_swl,
    input  logic              cfg_pad_hi,
    input  logic              cfg_right_align,
    input  logic              cfg_delay,
    input  logic              cfg_sck_inv,
    input  logic              cfg_ws_inv,
    output logic              sck_o,
    output logic              ws_o,
    output logic              sd_o,
    output logic              underflow
);
    logic              sck_int, tick;
    logic              fifo_pop, fifo_empty;
    logic [MAX_DW-1:0] fifo_data;
    logic              ws_q;

    sat_fifo #(.DW(MAX_DW), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(fifo_pop), .rd_data(fifo_data),
        .full(wr_full), .empty(fifo_empty)
    );

    sat_bitclk #(.HALF_DIV(HALF_DIV)) u_clk (
        .clk(clk), .rst_n(rst_n), .sck_int(sck_int), .tick(tick)
    );

    sat_slot_seq #(.MAX_DW(MAX_DW), .DLEN_W(DLEN_W), .SWL_W(SWL_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .cfg_chnl(cfg_chnl), .cfg_dlen(cfg_dlen), .cfg_swl(cfg_swl),
        .cfg_pad_hi(cfg_pad_hi), .cfg_right_align(cfg_right_align),
        .cfg_delay(cfg_delay),
        .fifo_data(fifo_data), .fifo_empty(fifo_empty), .fifo_pop(fifo_pop),
        .sd_q(sd_o), .ws_q(ws_q), .underflow(underflow)
    );

    assign sck_o = sck_int ^ cfg_sck_inv;
    assign ws_o  = ws_q ^ cfg_ws_inv;

    AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> !fifo_empty); // R9

endmodule

// File: tb/sim_mc_audio_tx.sv
module sim_mc_audio_tx;
    localparam int MAX_DW   = 16;
    localparam int DEPTH    = 8;
    localparam int HALF_DIV = 2;
    localparam int SWL_W    = 7;
    localparam int DLEN_W   = $clog2(MAX_DW + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [MAX_DW-1:0] wr_data = '0;
    logic wr_full;
    logic [1:0] cfg_chnl = 2'b00;
    logic [DLEN_W-1:0] cfg_dlen = DLEN_W'(8);
    logic [SWL_W-1:0] cfg_swl = SWL_W'(8);
    logic cfg_pad_hi = 1'b0, cfg_right_align = 1'b0, cfg_delay = 1'b0;
    logic cfg_sck_inv = 1'b0, cfg_ws_inv = 1'b0;
    logic sck_o, ws_o, sd_o, underflow;

    int checks = 0;
    int failures = 0;
    logic [MAX_DW-1:0] words [0:63];
    int nw_accept;
    logic got_sd [0:1023];
    logic got_ws [0:1023];
    int rise_clk [0:1023];
    int clk_count = 0;

    always #4 clk = ~clk;
    always @(posedge clk) clk_count <= clk_count + 1;

    mc_audio_tx #(.MAX_DW(MAX_DW), .DEPTH(DEPTH), .HALF_DIV(HALF_DIV),
                  .SWL_W(SWL_W), .DLEN_W(DLEN_W)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wr_full(wr_full), .cfg_chnl(cfg_chnl), .cfg_dlen(cfg_dlen),
        .cfg_swl(cfg_swl), .cfg_pad_hi(cfg_pad_hi),
        .cfg_right_align(cfg_right_align), .cfg_delay(cfg_delay),
        .cfg_sck_inv(cfg_sck_inv), .cfg_ws_inv(cfg_ws_inv),
        .sck_o(sck_o), .ws_o(ws_o), .sd_o(sd_o), .underflow(underflow)
    );

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    function automatic int nwords();
        return int'(cfg_chnl) + 1;
    endfunction

    // Expected data bit for stream position i (R1 R2 R3 R4 R9).
    function automatic logic exp_sd(int i);
        int swl = int'(cfg_swl);
        int dl = int'(cfg_dlen);
        int nb = nwords() * dl;
        int q = i % swl;
        int s = i / swl;
        int ds = cfg_right_align ? (swl - nb) : 0;
        if (q >= ds && q < ds + nb) begin
            int d = q - ds;
            int wi = s * nwords() + d / dl;
            int b = dl - 1 - (d % dl);
            return (wi < nw_accept) ? words[wi][b] : 1'b0;
        end
        return cfg_pad_hi;
    endfunction

    // Expected word-select level for stream position i (R5 R6).
    function automatic logic exp_ws(int i);
        int swl = int'(cfg_swl);
        int q = i % swl;
        logic h = logic'((i / swl) % 2);
        logic l = (cfg_delay && q == swl - 1) ? ~h : h;
        return l ^ cfg_ws_inv;
    endfunction

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10 reset state
        check(sd_o == 1'b0, "R10 sd_o after reset", sd_o, 0);
        check(ws_o == cfg_ws_inv && sck_o == cfg_sck_inv,
              "R10 ws_o/sck_o after reset", {ws_o, sck_o}, {cfg_ws_inv, cfg_sck_inv});
        check(!underflow && !wr_full, "R10 flags after reset", {underflow, wr_full}, 0);
    endtask

    task automatic feeder(input int n, input bit wait_full);
        for (int k = 0; k < n; k++) begin
            if (wait_full) while (wr_full) @(negedge clk);
            wr_en = 1'b1;
            wr_data = words[k];
            @(negedge clk);
        end
        wr_en = 1'b0;
    endtask

    task automatic monitor(input int t);
        logic prev = 1'b0;
        bit skipped = 1'b0;
        int idx = 0;
        while (idx < t) begin
            @(negedge clk);
            if (!prev && (sck_o ^ cfg_sck_inv)) begin
                if (!skipped) skipped = 1'b1;
                else begin
                    got_sd[idx] = sd_o;
                    got_ws[idx] = ws_o;
                    rise_clk[idx] = clk_count;
                    idx++;
                end
            end
            prev = sck_o ^ cfg_sck_inv;
        end
    endtask

    // One scenario: reset, feed, observe four system words, compare.
    task automatic run_case(input int n_write, input int n_acc, input bit wait_full);
        int t = 4 * int'(cfg_swl);
        int bad_sd = -1;
        int bad_ws = -1;
        nw_accept = n_acc;
        do_reset();
        fork
            feeder(n_write, wait_full);
            monitor(t);
        join
        for (int i = 0; i < t; i++) begin
            if (bad_sd < 0 && got_sd[i] !== exp_sd(i)) bad_sd = i;
            if (bad_ws < 0 && got_ws[i] !== exp_ws(i)) bad_ws = i;
        end
        check(bad_sd < 0, "R1 R2 R3 R4 data stream, first bad bit value",
              (bad_sd < 0) ? 0 : int'(got_sd[bad_sd]),
              (bad_sd < 0) ? 0 : int'(exp_sd(bad_sd)));
        check(bad_ws < 0, "R5 R6 word select, first bad level",
              (bad_ws < 0) ? 0 : int'(got_ws[bad_ws]),
              (bad_ws < 0) ? 0 : int'(exp_ws(bad_ws)));
        check(rise_clk[t-1] - rise_clk[t-2] == 2 * HALF_DIV, "R7 bit clock period",
              rise_clk[t-1] - rise_clk[t-2], 2 * HALF_DIV);
        check(underflow == (4 * nwords() > n_acc), "R9 underflow flag",
              underflow, int'(4 * nwords() > n_acc));
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int k = 0; k < 64; k++) words[k] = MAX_DW'($urandom);

        // Directed: two channels, no padding (R2).
        cfg_chnl = 2'b01; cfg_dlen = DLEN_W'(8); cfg_swl = SWL_W'(16);
        cfg_pad_hi = 1'b1; cfg_right_align = 1'b0; cfg_delay = 1'b1;
        cfg_sck_inv = 1'b0; cfg_ws_inv = 1'b0;
        run_case(8, 8, 1'b1);

        // Directed: writes into a full buffer are dropped (R8), then underflow (R9).
        cfg_chnl = 2'b11; cfg_dlen = DLEN_W'(16); cfg_swl = SWL_W'(127);
        cfg_pad_hi = 1'b0; cfg_right_align = 1'b1; cfg_delay = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < DEPTH + 2; k++) begin
            wr_en = 1'b1;
            wr_data = words[k];
            @(negedge clk);
        end
        wr_en = 1'b0;
        check(wr_full == 1'b1, "R8 full after DEPTH+2 writes", wr_full, 1);
        run_case(DEPTH + 2, DEPTH, 1'b0);

        // Random configurations.
        for (int r = 0; r < 14; r++) begin
            int n, dl, nb;
            cfg_chnl = 2'($urandom_range(0, 3));
            n = int'(cfg_chnl) + 1;
            dl = int'($urandom_range(4, MAX_DW));
            nb = n * dl;
            cfg_dlen = DLEN_W'(dl);
            cfg_swl = SWL_W'(nb + int'($urandom_range(0, 8)));
            cfg_pad_hi = 1'($urandom);
            cfg_right_align = 1'($urandom);
            cfg_delay = 1'($urandom);
            cfg_sck_inv = 1'($urandom);
            cfg_ws_inv = 1'($urandom);
            for (int k = 0; k < 64; k++) words[k] = MAX_DW'($urandom);
            if ($urandom_range(0, 2) == 0) run_case(4 * n - 1, 4 * n - 1, 1'b1);
            else                           run_case(4 * n, 4 * n, 1'b1);
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule